// File: doc/BRIEF.md
# Multicycle Word-Addressed 32-bit Processor Core

This block is a small 32-bit load-store processor core. A finite state machine steps a datapath that is built around three internal buses: two operand buses feed an ALU and one result bus carries its output back to the holding registers. Each instruction passes through fetch, decode with register read, execute and, for loads and stores only, a memory phase, followed by a writeback phase for instructions that produce a register value. There are sixteen 32-bit registers, and register 0 is tied to zero. Memory is addressed in whole 32-bit words with a 20-bit address, so a complete jump or load/store address fits inside one instruction word. All instruction fields lie on hex-digit boundaries.

The core drives a synchronous request/acknowledge memory port. A request stays asserted, with a stable address, until an acknowledge is seen together with the step enable. The step-enable input gates every state transition. A debug controller can therefore hold the core still or advance it one clock at a time. The core has no branch or load delay slots. The instruction after a load sees the loaded value, and the instruction after a taken branch never runs.

Top module: `cpu_core`

## Requirements
- R1: When reset (active-low, synchronous) is released, the core is in fetch with pc 0: mem_req is 1, mem_addr is 0, mem_we is 0, halted is 0 and ovf_flag is 0.
- R2: Instruction fields are opcode [31:28], rd [27:24] and rs [23:20]. Opcode 0 is the register form: func [19:16] and rt [3:0], computing rd = rs op rt. The func codes are 0 add, 1 add unsigned, 2 sub, 3 sub unsigned, 4 and, 5 or, 6 xor, 7 shift left, 8 shift right logical, 9 shift right arithmetic, A set-less-than signed and B set-less-than unsigned. Shifts use the low 5 bits of the second operand.
- R3: Opcode 1 is the immediate form: func [19:16] and imm [15:0], computing rd = rs op imm. The immediate is sign-extended for func 0, 2 and A, and zero-extended for every other func.
- R4: ovf_flag is updated by every opcode 0 or 1 instruction. It becomes 1 when a signed add (func 0) or signed subtract (func 2) overflows in two's complement, and 0 for any other result or func, including the unsigned forms. Other instructions leave it unchanged.
- R5: Register 0 always reads as zero, and writes to it are ignored.
- R6: Opcode 2 loads rd from mem[(rs + addr) mod 2^20] and opcode 3 stores rd to that word, where addr is [19:0]. A store drives mem_we=1, mem_wdata=rd and that address.
- R7: The instruction directly after a load can use the loaded register value.
- R8: Opcode 4 jumps to addr. Opcodes 5, 6 and 7 branch to addr when rd==rs, rd!=rs and rd<rs (signed) respectively. A taken transfer skips the next sequential instruction. Any other instruction continues at pc+1.
- R9: While step_en is 0, the state, pc, registers and memory outputs do not change.
- R10: A memory request (fetch, load or store) keeps mem_req and mem_addr stable until mem_ack and step_en are both 1 on the same clock edge.
- R11: Opcode F halts the core: halted goes to 1 and stays 1, no further memory requests are made, and pc holds the address of the halt instruction plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | State transition enable for cycle stepping |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes when high with step_en |
| halted | output | 1 | Core has executed a halt |
| ovf_flag | output | 1 | Signed overflow of last ALU instruction |
| pc_dbg | output | 20 | Current program counter |

## Verification
A single program is run that pairs each ALU func with operands chosen to separate its variants. Examples are sign against zero extension of the same 0xFFFF immediate, signed against unsigned compare on -1, logical against arithmetic right shift of a negative value, and signed against unsigned add of 0x7FFFFFFF to itself. Every store is checked against a queue of expected address, data and flag values, so a store that should have been skipped (after a taken branch or jump) shows up as a mismatch. Memory acknowledge latency varies with the address, and step_en is dropped periodically and for a longer window. Those two patterns separate correct request holding and freezing from logic that only works with immediate acknowledges and continuous stepping. Base-plus-offset stores that cross 2^20 check the address wrap.

// File: rtl/cpu_pkg.sv
// Shared constants and types for the processor core.
// Assumes a 32-bit instruction word with all fields on 4-bit boundaries.
package cpu_pkg;
    localparam int XLEN    = 32;
    localparam int ALEN    = 20;
    localparam int NREG    = 16;
    localparam int RIDX    = $clog2(NREG);

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_DECODE = 3'd1,
        S_EXEC   = 3'd2,
        S_MEM    = 3'd3,
        S_WB     = 3'd4,
        S_HALT   = 3'd5
    } state_t;

    localparam logic [3:0] OP_ALUR = 4'h0;
    localparam logic [3:0] OP_ALUI = 4'h1;
    localparam logic [3:0] OP_LD   = 4'h2;
    localparam logic [3:0] OP_ST   = 4'h3;
    localparam logic [3:0] OP_JMP  = 4'h4;
    localparam logic [3:0] OP_BEQ  = 4'h5;
    localparam logic [3:0] OP_BNE  = 4'h6;
    localparam logic [3:0] OP_BLT  = 4'h7;
    localparam logic [3:0] OP_HALT = 4'hF;

    localparam logic [3:0] F_ADD  = 4'h0;
    localparam logic [3:0] F_ADDU = 4'h1;
    localparam logic [3:0] F_SUB  = 4'h2;
    localparam logic [3:0] F_SUBU = 4'h3;
    localparam logic [3:0] F_AND  = 4'h4;
    localparam logic [3:0] F_OR   = 4'h5;
    localparam logic [3:0] F_XOR  = 4'h6;
    localparam logic [3:0] F_SLL  = 4'h7;
    localparam logic [3:0] F_SRL  = 4'h8;
    localparam logic [3:0] F_SRA  = 4'h9;
    localparam logic [3:0] F_SLT  = 4'hA;
    localparam logic [3:0] F_SLTU = 4'hB;
endpackage

// File: rtl/cpu_regfile.sv
// General-purpose register file: two combinational read ports, one
// synchronous write port. Entry 0 is hard-wired to zero.
// Assumes DEPTH is a power of two.
module cpu_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata
);
    logic [WIDTH-1:0] regs [DEPTH];

    // Storage update; index 0 is never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with register 0 forced to zero.
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
    end

    AST_R0_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (regs[0] == '0)); // R5
endmodule

// File: rtl/cpu_alu.sv
// Combinational ALU between the two operand buses and the result bus.
// Flags two's-complement overflow only for the signed add and subtract.
// Assumes WIDTH >= 32 so that a 5-bit shift amount is meaningful.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [3:0]       func,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result,
    output logic             ovf
);
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] dif;
    logic [SHW-1:0]   shamt;

    // Result selection and overflow detection.
    always_comb begin
        sum    = op_a + op_b;
        dif    = op_a - op_b;
        shamt  = op_b[SHW-1:0];
        ovf    = 1'b0;
        result = '0;
        case (func)
            F_ADD: begin
                result = sum;
                ovf    = (op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1]);
            end
            F_ADDU: result = sum;
            F_SUB: begin
                result = dif;
                ovf    = (op_a[WIDTH-1] != op_b[WIDTH-1]) && (dif[WIDTH-1] != op_a[WIDTH-1]);
            end
            F_SUBU: result = dif;
            F_AND:  result = op_a & op_b;
            F_OR:   result = op_a | op_b;
            F_XOR:  result = op_a ^ op_b;
            F_SLL:  result = op_a << shamt;
            F_SRL:  result = op_a >> shamt;
            F_SRA:  result = $signed(op_a) >>> shamt;
            F_SLT:  result = {{(WIDTH-1){1'b0}}, $signed(op_a) < $signed(op_b)};
            F_SLTU: result = {{(WIDTH-1){1'b0}}, op_a < op_b};
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/cpu_ctrl.sv
// Instruction sequencer: fetch, decode, execute, optional memory phase,
// optional writeback. Every transition requires step_en; memory phases
// additionally require mem_ack. Assumes the opcode is stable from decode on.
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en,
    input  logic       mem_ack,
    input  logic [3:0] opcode,
    output state_t     state_q,
    output logic       advance
);
    state_t state_d;
    logic   in_mem;

    // Transition enable for the current state.
    always_comb begin
        in_mem  = (state_q == S_FETCH) || (state_q == S_MEM);
        advance = step_en && (state_q != S_HALT) && (!in_mem || mem_ack);
    end

    // Next-state selection by phase and opcode.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: state_d = (opcode == OP_HALT) ? S_HALT : S_EXEC;
            S_EXEC: begin
                if (opcode == OP_ALUR || opcode == OP_ALUI)  state_d = S_WB;
                else if (opcode == OP_LD || opcode == OP_ST) state_d = S_MEM;
                else                                         state_d = S_FETCH;
            end
            S_MEM:    state_d = (opcode == OP_LD) ? S_WB : S_FETCH;
            S_WB:     state_d = S_FETCH;
            default:  state_d = S_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= S_FETCH;
        else if (advance) state_q <= state_d;
    end

    AST_FROZEN_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(state_q)); // R9
    AST_WAITS_FOR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_FETCH || state_q == S_MEM) && !mem_ack) |=> $stable(state_q)); // R10
    AST_HALT_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (state_q == S_HALT)); // R11
endmodule

// File: rtl/cpu_core.sv
// Multicycle 32-bit load-store core with a word-addressed 20-bit memory
// port. Datapath: operand bus A from the rs holding register, operand bus
// B from the second-source mux, result bus from the ALU. Assumes memory
// keeps mem_rdata valid whenever mem_ack is high.
module cpu_core
    import cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic             mem_req,
    output logic             mem_we,
    output logic [ALEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ack,
    output logic             halted,
    output logic             ovf_flag,
    output logic [ALEN-1:0]  pc_dbg
);
    localparam int IMMW = 16;

    state_t            state_q;
    logic              adv;
    logic [ALEN-1:0]   pc_q;
    logic [XLEN-1:0]   ir_q, a_q, b_q, r_q;
    logic              ovf_q;

    logic [3:0]        opc, rd, rs, rt, func, alu_func;
    logic [IMMW-1:0]   imm;
    logic [ALEN-1:0]   jaddr;
    logic [RIDX-1:0]   rb_sel;
    logic [XLEN-1:0]   rf_a, rf_b;
    logic [XLEN-1:0]   bus_a, bus_b, bus_r;
    logic              alu_ovf, imm_sext, is_alu, is_mem, taken;

    // Field extraction from the instruction register.
    always_comb begin
        opc    = ir_q[31:28];
        rd     = ir_q[27:24];
        rs     = ir_q[23:20];
        func   = ir_q[19:16];
        rt     = ir_q[3:0];
        imm    = ir_q[15:0];
        jaddr  = ir_q[ALEN-1:0];
        is_alu = (opc == OP_ALUR) || (opc == OP_ALUI);
        is_mem = (opc == OP_LD) || (opc == OP_ST);
        rb_sel = (opc == OP_ALUR) ? rt : rd;
    end

    cpu_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .mem_ack (mem_ack),
        .opcode  (opc),
        .state_q (state_q),
        .advance (adv)
    );

    cpu_regfile #(.WIDTH(XLEN), .DEPTH(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (rs),
        .raddr_b (rb_sel),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .we      (adv && state_q == S_WB),
        .waddr   (rd),
        .wdata   (r_q)
    );

    // Operand bus drive: A from rs, B from rt/rd, immediate or address.
    always_comb begin
        imm_sext = (func == F_ADD) || (func == F_SUB) || (func == F_SLT);
        bus_a    = a_q;
        case (opc)
            OP_ALUI: bus_b = imm_sext ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
                                      : {{(XLEN-IMMW){1'b0}}, imm};
            OP_LD, OP_ST: bus_b = {{(XLEN-ALEN){1'b0}}, jaddr};
            default: bus_b = b_q;
        endcase
        alu_func = is_mem ? F_ADDU : func;
    end

    cpu_alu #(.WIDTH(XLEN)) u_alu (
        .func   (alu_func),
        .op_a   (bus_a),
        .op_b   (bus_b),
        .result (bus_r),
        .ovf    (alu_ovf)
    );

    // Control-transfer decision; b_q holds rd, a_q holds rs.
    always_comb begin
        case (opc)
            OP_JMP:  taken = 1'b1;
            OP_BEQ:  taken = (b_q == a_q);
            OP_BNE:  taken = (b_q != a_q);
            OP_BLT:  taken = ($signed(b_q) < $signed(a_q));
            default: taken = 1'b0;
        endcase
    end

    // Datapath holding registers, updated only when the sequencer advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            r_q   <= '0;
            ovf_q <= 1'b0;
        end else if (adv) begin
            case (state_q)
                S_FETCH: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + 1'b1;
                end
                S_DECODE: begin
                    a_q <= rf_a;
                    b_q <= rf_b;
                end
                S_EXEC: begin
                    if (is_alu) begin
                        r_q   <= bus_r;
                        ovf_q <= alu_ovf;
                    end else if (is_mem) begin
                        r_q <= bus_r;
                    end else if (taken) begin
                        pc_q <= jaddr;
                    end
                end
                S_MEM: begin
                    if (opc == OP_LD) r_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Memory port and status outputs.
    always_comb begin
        mem_req   = (state_q == S_FETCH) || (state_q == S_MEM);
        mem_we    = (state_q == S_MEM) && (opc == OP_ST);
        mem_addr  = (state_q == S_MEM) ? r_q[ALEN-1:0] : pc_q;
        mem_wdata = b_q;
        halted    = (state_q == S_HALT);
        ovf_flag  = ovf_q;
        pc_dbg    = pc_q;
    end

    AST_PC_INCREMENTS_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && adv) |=> (pc_q == $past(pc_q) + 1'b1)); // R8
    AST_UNSIGNED_NEVER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && adv && is_alu && (func == F_ADDU || func == F_SUBU)) |=> !ovf_flag); // R4
    AST_WRITE_ONLY_IN_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R6
    AST_REQUEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !(mem_ack && step_en)) |=> (mem_req && $stable(mem_addr))); // R10
    AST_HALT_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req); // R11
endmodule

// File: tb/cpu_core_test.sv
// Scoreboard bench: the program loader pushes every expected store into a
// queue; a monitor pops and compares each store the core performs.
module cpu_core_test;
    typedef struct {
        logic [19:0] a;
        logic [31:0] d;
        logic        o;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        mem_req, mem_we, mem_ack, halted, ovf_flag;
    logic [19:0] mem_addr, pc_dbg;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] mem [256];
    logic [2:0]  wait_cnt;
    exp_t        sb [$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          wp = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    cpu_core uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .halted(halted), .ovf_flag(ovf_flag), .pc_dbg(pc_dbg)
    );

    // Memory model: latency depends on the low address bits.
    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ack   = mem_req && (wait_cnt >= {1'b0, mem_addr[1:0]});

    always @(posedge clk) begin
        if (!rst_n || !mem_req || (mem_ack && step_en)) wait_cnt <= '0;
        else if (wait_cnt != 3'd7) wait_cnt <= wait_cnt + 1'b1;
        if (rst_n && mem_req && mem_we && mem_ack && step_en)
            mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [3:0] f, rd, rs, rt);
        return {4'h0, rd, rs, f, 12'h000, rt};
    endfunction
    function automatic logic [31:0] enc_i(input logic [3:0] f, rd, rs, input logic [15:0] im);
        return {4'h1, rd, rs, f, im};
    endfunction
    function automatic logic [31:0] enc_j(input logic [3:0] op, rd, rs, input logic [19:0] ad);
        return {op, rd, rs, ad};
    endfunction

    task automatic put(input logic [31:0] w);
        mem[wp] = w;
        wp++;
    endtask
    task automatic expect_st(input logic [19:0] a, input logic [31:0] d, input logic o);
        exp_t e;
        e.a = a; e.d = d; e.o = o;
        sb.push_back(e);
    endtask

    // Monitor: compare each completed store with the queue head.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack && step_en) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "unexpected store addr", {12'h0, mem_addr}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(mem_addr == e.a, "R6", "store address", {12'h0, mem_addr}, {12'h0, e.a});
                chk(mem_wdata == e.d, "R2/R3/R7", "store data", mem_wdata, e.d);
                chk(ovf_flag == e.o, "R4", "overflow flag", {31'h0, ovf_flag}, {31'h0, e.o});
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected halted", 0);
            finish_run();
        end
    end

    // Program load and driver.
    initial begin
        logic [19:0] halt_at;
        logic [19:0] pc_hold, addr_hold;
        int cyc;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[8'h90] = 32'h12345678;
        put(enc_i(4'h0, 4'd1, 4'd0, 16'h7FFF));  // r1 = 0x7FFF
        put(enc_i(4'h0, 4'd2, 4'd0, 16'hFFFF));  // r2 = -1 (R3 sign)
        put(enc_i(4'h1, 4'd3, 4'd0, 16'hFFFF));  // r3 = 0xFFFF (R3 zero)
        put(enc_j(4'h3, 4'd1, 4'd0, 20'h80)); expect_st(20'h80, 32'h00007FFF, 1'b0);
        put(enc_j(4'h3, 4'd2, 4'd0, 20'h81)); expect_st(20'h81, 32'hFFFFFFFF, 1'b0);
        put(enc_j(4'h3, 4'd3, 4'd0, 20'h82)); expect_st(20'h82, 32'h0000FFFF, 1'b0);
        put(enc_r(4'h0, 4'd4, 4'd1, 4'd2));   // R2 add
        put(enc_j(4'h3, 4'd4, 4'd0, 20'h83)); expect_st(20'h83, 32'h00007FFE, 1'b0);
        put(enc_r(4'h2, 4'd5, 4'd3, 4'd1));   // R2 sub
        put(enc_j(4'h3, 4'd5, 4'd0, 20'h84)); expect_st(20'h84, 32'h00008000, 1'b0);
        put(enc_i(4'h0, 4'd0, 4'd0, 16'h0005)); // R5 write r0
        put(enc_j(4'h3, 4'd0, 4'd0, 20'h85)); expect_st(20'h85, 32'h0, 1'b0);
        put(enc_j(4'h2, 4'd6, 4'd0, 20'h90)); // R7 load
        put(enc_r(4'h0, 4'd7, 4'd6, 4'd6));   // uses it at once
        put(enc_j(4'h3, 4'd7, 4'd0, 20'h86)); expect_st(20'h86, 32'h2468ACF0, 1'b0);
        put(enc_j(4'h5, 4'd0, 4'd0, 20'(wp + 2))); // R8 beq taken
        put(enc_j(4'h3, 4'd2, 4'd0, 20'h87));      // must be skipped
        put(enc_j(4'h7, 4'd2, 4'd1, 20'(wp + 2))); // R8 blt -1<0x7FFF taken
        put(enc_j(4'h3, 4'd2, 4'd0, 20'h87));      // must be skipped
        put(enc_j(4'h6, 4'd1, 4'd1, 20'h30));      // bne not taken
        put(enc_j(4'h7, 4'd1, 4'd2, 20'h30));      // blt not taken
        put(enc_i(4'h6, 4'd8, 4'd1, 16'h00FF));
        put(enc_j(4'h3, 4'd8, 4'd0, 20'h88)); expect_st(20'h88, 32'h00007F00, 1'b0);
        put(enc_i(4'h7, 4'd9, 4'd1, 16'd4));
        put(enc_i(4'h8, 4'd10, 4'd2, 16'd28));
        put(enc_i(4'h9, 4'd11, 4'd2, 16'd8));
        put(enc_j(4'h3, 4'd9, 4'd0, 20'h89));  expect_st(20'h89, 32'h0007FFF0, 1'b0);
        put(enc_j(4'h3, 4'd10, 4'd0, 20'h8A)); expect_st(20'h8A, 32'h0000000F, 1'b0);
        put(enc_j(4'h3, 4'd11, 4'd0, 20'h8B)); expect_st(20'h8B, 32'hFFFFFFFF, 1'b0);
        put(enc_r(4'hA, 4'd12, 4'd2, 4'd1));
        put(enc_r(4'hB, 4'd13, 4'd2, 4'd1));
        put(enc_j(4'h3, 4'd12, 4'd0, 20'h8C)); expect_st(20'h8C, 32'h1, 1'b0);
        put(enc_j(4'h3, 4'd13, 4'd0, 20'h8D)); expect_st(20'h8D, 32'h0, 1'b0);
        put(enc_i(4'hB, 4'd14, 4'd1, 16'hFFFF)); // R3 sltu zero-extended
        put(enc_j(4'h3, 4'd14, 4'd0, 20'h8E)); expect_st(20'h8E, 32'h1, 1'b0);
        put(enc_j(4'h3, 4'd1, 4'd3, 20'h81)); expect_st(20'h10080, 32'h00007FFF, 1'b0); // R6 base
        put(enc_j(4'h3, 4'd1, 4'd2, 20'h90)); expect_st(20'h0008F, 32'h00007FFF, 1'b0); // R6 wrap
        put(enc_j(4'h4, 4'd0, 4'd0, 20'h40)); // R8 jump
        put(enc_j(4'h3, 4'd2, 4'd0, 20'h87)); // must be skipped
        wp = 32'h40;
        put(enc_i(4'h8, 4'd14, 4'd2, 16'd1));  // r14 = 0x7FFFFFFF
        put(enc_r(4'h0, 4'd15, 4'd14, 4'd14)); // R4 signed add overflows
        put(enc_j(4'h3, 4'd15, 4'd0, 20'hA0)); expect_st(20'hA0, 32'hFFFFFFFE, 1'b1);
        put(enc_r(4'h1, 4'd15, 4'd14, 4'd14)); // unsigned add: no flag
        put(enc_j(4'h3, 4'd15, 4'd0, 20'hA1)); expect_st(20'hA1, 32'hFFFFFFFE, 1'b0);
        put(enc_i(4'h7, 4'd3, 4'd2, 16'd31));  // r3 = 0x80000000
        put(enc_i(4'h2, 4'd4, 4'd3, 16'd1));   // R4 signed sub overflows
        put(enc_j(4'h3, 4'd4, 4'd0, 20'hA2)); expect_st(20'hA2, 32'h7FFFFFFF, 1'b1);
        put(enc_i(4'h3, 4'd4, 4'd3, 16'd1));   // unsigned sub: no flag
        put(enc_j(4'h3, 4'd4, 4'd0, 20'hA3)); expect_st(20'hA3, 32'h7FFFFFFF, 1'b0);
        halt_at = 20'(wp);
        put(32'hF000_0000);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_req == 1'b1, "R1", "mem_req", {31'h0, mem_req}, 32'h1);
        chk(mem_addr == 20'h0, "R1", "mem_addr", {12'h0, mem_addr}, 32'h0);
        chk(mem_we == 1'b0, "R1", "mem_we", {31'h0, mem_we}, 32'h0);
        chk(halted == 1'b0, "R1", "halted", {31'h0, halted}, 32'h0);
        chk(ovf_flag == 1'b0, "R1", "ovf_flag", {31'h0, ovf_flag}, 32'h0);

        cyc = 0;
        while (!halted) begin
            @(posedge clk);
            #1;
            cyc++;
            if (cyc >= 200 && cyc < 206) step_en = 1'b0;
            else step_en = (cyc % 5) != 3;
            if (cyc == 200) begin
                @(negedge clk);
                pc_hold   = pc_dbg;
                addr_hold = mem_addr;
            end
            if (cyc == 205) begin
                @(negedge clk);
                chk(pc_dbg == pc_hold, "R9", "pc frozen", {12'h0, pc_dbg}, {12'h0, pc_hold});
                chk(mem_addr == addr_hold, "R9", "addr frozen", {12'h0, mem_addr}, {12'h0, addr_hold});
            end
        end
        step_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(halted == 1'b1, "R11", "halted", {31'h0, halted}, 32'h1);
        chk(mem_req == 1'b0, "R11", "no request", {31'h0, mem_req}, 32'h0);
        chk(pc_dbg == halt_at + 1'b1, "R11", "pc after halt", {12'h0, pc_dbg}, {12'h0, halt_at + 20'h1});
        chk(sb.size() == 0, "R8", "stores outstanding", sb.size(), 32'h0);
        chk(mem[8'h85] == 32'h0, "R5", "r0 stored", mem[8'h85], 32'h0);
        chk(mem[8'h87] == 32'h0, "R8", "skipped slot", mem[8'h87], 32'h0);
        chk(mem[8'h86] == 32'h2468ACF0, "R7", "load-use", mem[8'h86], 32'h2468ACF0);
        finished = 1'b1;
        finish_run();
    end
endmodule